// File: doc/BRIEF.md
# Gain-Normalized CIC Decimator

This block is the rate-reduction stage of a digital downconverter path. It takes one signed sample on each clock where the input strobe is high and runs it through a cascade of integrators at the input rate. It keeps every R-th accepted sample and passes it through an equal number of comb (differencing) stages at the reduced rate. It then divides the result by the filter's DC gain R^N, so a constant input comes out at the same value.

The stage count, decimation factor and input width are parameters. The output is always a signed 32-bit word with a one-cycle valid pulse. Decimation is counted in accepted samples, never in clock cycles, so an upstream source may stall freely. The internal datapath uses two's-complement wraparound, which is harmless because the comb differences cancel any intermediate overflow.

Top module: `cic_decim_norm`

## Requirements
- R1: While reset is low, and after it, `out_valid` is 0 and `out_data` is 0. Reset clears the integrators, the comb delays and the sample counter, so a run after a mid-stream reset behaves exactly like a run from power-up.
- R2: Each accepted sample updates the integrator cascade: the first stage adds the sample, and every later stage adds the just-updated value of the stage before it.
- R3: Clock cycles with `in_valid` low change neither the integrators, nor the sample count, nor the comb state, nor the output.
- R4: A decimated value is taken on the R-th, 2R-th, 3R-th and later accepted samples counted from reset, using the last integrator's value after that sample's update.
- R5: Each comb stage outputs its input minus the input it received at the previous decimated instant (differential delay one), then stores the current input.
- R6: `out_valid` is high for exactly one cycle. It rises at the clock edge that follows the edge accepting each R-th sample.
- R7: `out_data` keeps its value between decimated outputs.
- R8: The comb result is divided by R^N, rounding toward negative infinity. For example, with N=1 and R=2, the accepted pair 100, -301 gives -101.
- R9: A normalized value above 2147483647 is output as 32'h7FFFFFFF, and one below -2147483648 as 32'h80000000. The limits themselves pass unchanged.
- R10: After a constant input has been held for at least N·R accepted samples, the output equals that constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new decimated output |
| out_data | output | 32 | Signed, gain-normalized, clamped output |

## Verification
The bench feeds each sample to a behavioural reference model as the rising edge accepts it. When that sample is the R-th, the model schedules an output for the next edge, which matches the single register between the decimation strobe and the output. Both `out_valid` and `out_data` are compared on the falling edge of every cycle, so an output that is early, late or longer than one cycle shows up as a mismatch. A second instance, with N=1, R=2 and 36-bit input, checks rounding and clamping: two accepted samples, then one idle edge, then the result is read half a cycle later.

// File: rtl/cic_norm_pkg.sv
`timescale 1ns/1ps
package cic_norm_pkg;
  localparam int OUT_W = 32;

  function automatic longint ipow(input int base, input int expo);
    longint acc;
    acc = 1;
    for (int i = 0; i < expo; i++) acc = acc * longint'(base);
    return acc;
  endfunction
endpackage

// File: rtl/cic_integ_chain.sv
`timescale 1ns/1ps
module cic_integ_chain #(
  parameter int IN_W  = 16,
  parameter int NSTG  = 3,
  parameter int ACC_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [IN_W-1:0]   din,
  output logic [ACC_W-1:0]  last_next
);
  localparam int EXT_W = ACC_W - IN_W;

  logic [ACC_W-1:0] din_ext;
  logic [ACC_W-1:0] acc_q [NSTG];
  logic [ACC_W-1:0] acc_d [NSTG];

  assign din_ext = {{EXT_W{din[IN_W-1]}}, din};

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign acc_d[k] = acc_q[k] + din_ext;
    end else begin : g_rest
      assign acc_d[k] = acc_q[k] + acc_d[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q[k] <= '0;
      else if (en) acc_q[k] <= acc_d[k];
    end
  end

  assign last_next = acc_d[NSTG-1];

  // R3: no update without a strobe
  p_integ_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q[NSTG-1]));
  // R2: first stage absorbs the sample
  p_integ_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc_q[0] == $past(acc_q[0]) + $past(din_ext));
endmodule

// File: rtl/cic_rate_ctr.sv
`timescale 1ns/1ps
module cic_rate_ctr #(
  parameter int RATE  = 8,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  assign at_top = (cnt_q == CNT_W'(RATE - 1));
  assign wrap   = en && at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: count stays inside one decimation window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < RATE);
  // R3: idle cycles do not move the count
  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/cic_comb_chain.sv
`timescale 1ns/1ps
module cic_comb_chain #(
  parameter int NSTG  = 3,
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] stg_in  [NSTG];
  logic [ACC_W-1:0] stg_out [NSTG];
  logic [ACC_W-1:0] dly_q   [NSTG];

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stg_in[k] = din;
    end else begin : g_rest
      assign stg_in[k] = stg_out[k-1];
    end

    assign stg_out[k] = stg_in[k] - dly_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dly_q[k] <= '0;
      else if (en) dly_q[k] <= stg_in[k];
    end
  end

  assign dout = stg_out[NSTG-1];

  // R5: delay element captures the decimated input
  p_comb_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> dly_q[0] == $past(din));
  // R3: comb state only moves at decimated instants
  p_comb_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dly_q[NSTG-1]));
endmodule

// File: rtl/cic_out_norm.sv
`timescale 1ns/1ps
module cic_out_norm #(
  parameter int ACC_W = 25,
  parameter int NSTG  = 3,
  parameter int RATE  = 8,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam bit     IS_POW2 = ((RATE & (RATE - 1)) == 0);
  localparam longint OMAX    = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam longint OMIN    = -(longint'(1) <<< (OUT_W - 1));

  logic signed [63:0] wide;
  logic signed [63:0] quot;
  logic [OUT_W-1:0]   sat_d;
  logic [OUT_W-1:0]   data_d;
  logic               vld_d;

  assign wide = {{(64-ACC_W){din[ACC_W-1]}}, din};

  if (IS_POW2) begin : g_shift
    localparam int SHIFT = NSTG * $clog2(RATE);
    assign quot = wide >>> SHIFT;
  end else begin : g_divide
    localparam longint GAIN = cic_norm_pkg::ipow(RATE, NSTG);
    logic signed [63:0] q_trunc, r_trunc;
    assign q_trunc = wide / GAIN;
    assign r_trunc = wide % GAIN;
    assign quot    = ((r_trunc != 0) && wide[63]) ? q_trunc - 64'sd1 : q_trunc;
  end

  always_comb begin
    if (quot > OMAX)      sat_d = {1'b0, {(OUT_W-1){1'b1}}};
    else if (quot < OMIN) sat_d = {1'b1, {(OUT_W-1){1'b0}}};
    else                  sat_d = quot[OUT_W-1:0];
    data_d = en ? sat_d : out_data;
    vld_d  = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= data_d;
    end
  end

  // R6: output strobe lasts one cycle
  p_ovld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7: output word holds between decimated results
  p_odata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_data));
endmodule

// File: rtl/cic_decim_norm.sv
`timescale 1ns/1ps
module cic_decim_norm #(
  parameter int IN_W = 16,
  parameter int NSTG = 3,
  parameter int RATE = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic signed [IN_W-1:0]           in_data,
  output logic                             out_valid,
  output logic signed [cic_norm_pkg::OUT_W-1:0] out_data
);
  localparam int OUT_W = cic_norm_pkg::OUT_W;
  localparam int LOG_R = $clog2(RATE);
  localparam int CNT_W = (LOG_R > 0) ? LOG_R : 1;
  localparam int ACC_W = IN_W + NSTG * LOG_R;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             wrap;
  logic [ACC_W-1:0] integ_last;
  logic [ACC_W-1:0] snap_q, snap_d;
  logic             take_q, take_d;
  logic [ACC_W-1:0] comb_res;
  logic [OUT_W-1:0] out_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cic_integ_chain #(.IN_W(IN_W), .NSTG(NSTG), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n_s), .en(in_valid),
    .din(in_data), .last_next(integ_last)
  );

  cic_rate_ctr #(.RATE(RATE), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .en(in_valid), .wrap(wrap)
  );

  always_comb begin
    take_d = wrap;
    snap_d = wrap ? integ_last : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      take_q <= 1'b0;
      snap_q <= '0;
    end else begin
      take_q <= take_d;
      snap_q <= snap_d;
    end
  end

  cic_comb_chain #(.NSTG(NSTG), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n_s), .en(take_q),
    .din(snap_q), .dout(comb_res)
  );

  cic_out_norm #(.ACC_W(ACC_W), .NSTG(NSTG), .RATE(RATE), .OUT_W(OUT_W)) u_norm (
    .clk(clk), .rst_n(rst_n_s), .en(take_q), .din(comb_res),
    .out_valid(out_valid), .out_data(out_word)
  );

  assign out_data = out_word;

  // R6: result due one edge after the accepting edge
  p_out_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    wrap |-> ##2 out_valid);
  // R4: no output unless a window was completed
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wrap |=> ##1 !out_valid);
  // R1: reset state at the ports
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n_s |-> (!out_valid && out_data == '0));
endmodule

// File: tb/cic_decim_norm_tb_top.sv
`timescale 1ns/1ps
module cic_decim_norm_tb_top;
  localparam int IN_W = 16;
  localparam int NSTG = 3;
  localparam int RATE = 8;
  localparam longint GAIN = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic signed [31:0] out_data;

  logic s_valid = 1'b0;
  logic signed [35:0] s_din = '0;
  logic s_ovld;
  logic signed [31:0] s_out;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  longint integ [NSTG];
  longint cdly  [NSTG];
  int     cnt;
  bit     pend;
  longint pend_d;
  bit     exp_vld;
  longint exp_d;

  always #2 clk = ~clk;

  cic_decim_norm #(.IN_W(IN_W), .NSTG(NSTG), .RATE(RATE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  cic_decim_norm #(.IN_W(36), .NSTG(1), .RATE(2)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_data(s_din),
    .out_valid(s_ovld), .out_data(s_out)
  );

  function automatic longint fdiv(longint a, longint g);
    longint q;
    q = a / g;
    if ((a % g) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint clamp32(longint a);
    if (a > 64'sd2147483647) return 64'sd2147483647;
    if (a < -64'sd2147483648) return -64'sd2147483648;
    return a;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NSTG; k++) begin integ[k] = 0; cdly[k] = 0; end
    cnt = 0; pend = 0; pend_d = 0; exp_vld = 0; exp_d = 0;
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(bit v, int d);
    longint x, y;
    in_valid = v;
    in_data  = IN_W'(d);
    @(posedge clk);
    if (!rst_n) begin
      model_clear();
    end else begin
      exp_vld = pend;
      if (pend) exp_d = pend_d;
      pend = 0;
      if (v) begin
        integ[0] += longint'(d);
        for (int k = 1; k < NSTG; k++) integ[k] += integ[k-1];
        cnt++;
        if (cnt == RATE) begin
          cnt = 0;
          x = integ[NSTG-1];
          for (int k = 0; k < NSTG; k++) begin
            y = x - cdly[k];
            cdly[k] = x;
            x = y;
          end
          pend = 1;
          pend_d = clamp32(fdiv(x, GAIN));
        end
      end
    end
    @(negedge clk);
    chk(out_valid === exp_vld, {cur_req, " R6 valid"}, longint'(out_valid), longint'(exp_vld));
    chk(out_data === 32'(exp_d), {cur_req, " R7 data"}, longint'(out_data), exp_d);
  endtask

  task automatic sat_pair(longint a, longint b, longint expv, string req);
    s_valid = 1'b1; s_din = 36'(a);
    tick(0, 0);
    s_din = 36'(b);
    tick(0, 0);
    s_valid = 1'b0;
    tick(0, 0);
    chk(s_ovld === 1'b1, {req, " R6 sat valid"}, longint'(s_ovld), 1);
    chk(s_out === 32'(expv), req, longint'(s_out), expv);
    tick(0, 0);
    chk(s_ovld === 1'b0, "R6 sat pulse", longint'(s_ovld), 0);
    chk(s_out === 32'(expv), "R7 sat hold", longint'(s_out), expv);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lfsr;
    model_clear();
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    repeat (3) tick(0, 0);
    rst_n = 1'b1;
    repeat (4) tick(0, 0);

    // R2 R4 R5 R8: positive impulse, then zeros
    cur_req = "R2 R5";
    tick(1, 256);
    for (int i = 0; i < 40; i++) tick(1, 0);
    // negative impulse checks flooring
    cur_req = "R8";
    tick(1, -1);
    for (int i = 0; i < 40; i++) tick(1, 0);

    // R4: continuous ramp
    cur_req = "R4";
    for (int i = 0; i < 256; i++) tick(1, i);

    // R3: irregular strobes with long gaps
    cur_req = "R3";
    lfsr = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      tick(lfsr[0], ((i * 37) % 2001) - 1000);
    end
    repeat (20) tick(0, 0);

    // R10: DC gain is unity
    cur_req = "R10";
    for (int i = 0; i < 64; i++) tick(1, -1234);
    repeat (3) tick(0, 0);
    chk(out_data === -32'sd1234, "R10 dc level", longint'(out_data), -1234);

    // R1: reset in mid-window, then a fresh impulse run
    cur_req = "R1";
    for (int i = 0; i < 5; i++) tick(1, 999);
    rst_n = 1'b0;
    repeat (3) tick(0, 0);
    chk(out_valid === 1'b0 && out_data === 32'sd0, "R1 held reset", longint'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) tick(0, 0);
    tick(1, 512);
    for (int i = 0; i < 31; i++) tick(1, 0);

    // R9 R8: normalization and clamping on the wide instance
    sat_pair(64'sd34359738367, 64'sd34359738367, 64'sd2147483647, "R9 clamp high");
    sat_pair(-64'sd34359738368, -64'sd34359738368, -64'sd2147483648, "R9 clamp low");
    sat_pair(64'sd2147483647, 64'sd2147483647, 64'sd2147483647, "R9 upper limit");
    sat_pair(64'sd2147483648, 64'sd2147483648, 64'sd2147483647, "R9 just above");
    sat_pair(-64'sd2147483648, -64'sd2147483649, -64'sd2147483648, "R9 just below");
    sat_pair(64'sd100, -64'sd301, -64'sd101, "R8 floor");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule